// File: doc/BRIEF.md
# Discontinuous PWM Reference Generator

This block produces three modulation references for a carrier-based PWM stage. The references are 120 degrees apart and follow a discontinuous (clamped) shape instead of a plain sinusoid. A phase accumulator advances by a programmable increment on each sample strobe. Each phase angle is reduced to one of twelve 30-degree sectors. Depending on the sector, the reference is either pinned to a rail or computed as a weighted sum of the cosine and sine of the angle plus a constant offset. The weights use a programmable modulation index. Sine and cosine are both read from a single quarter-wave table.

Each reference holds a rail for 60 degrees around 0 and again around 180 degrees. The transistors in the affected leg therefore stop switching during those spans. Between the clamped spans, each reference follows sqrt(3)·m·cos ± m·sin ± 1 and is limited to the range -1 to +1. The typical operating point is a modulation index of 0.95 (code 15565) at a 50 Hz reference. At that frequency the increment is 50·2^32 divided by the strobe rate.

Top module: `dpwm_ref_gen`

## Requirements
- R1: While rst_n is low and after it returns high, ref_valid is 0 and all three references read 0 until the first result is delivered.
- R2: The phase accumulator is reset to 0 and is read before being advanced. Each strobe uses the current accumulator value as its angle and then adds phase_inc modulo 2^32. The first sample after reset therefore uses angle 0.
- R3: ref_valid is high for exactly one cycle per strobe: on the third rising edge after the edge that samples sample_stb high. It is low in every other cycle.
- R4: The angle index p is the top 10 bits of a phase's 32-bit angle. Its sector is floor(p·12/1024), which ranges from 0 to 11. The evaluation angle is 2π·p/1024.
- R5: In sectors 0 and 11 the reference is exactly +16384, which represents +1.0.
- R6: In sectors 5 and 6 the reference is exactly -16384, which represents -1.0.
- R7: Outside the clamped sectors, with m = mod_idx/16384, the reference is 16384 times the following expression, within 8 codes:
  - sectors 1–2: sqrt(3)·m·cos + m·sin − 1
  - sectors 3–4: sqrt(3)·m·cos − m·sin + 1
  - sectors 7–8: sqrt(3)·m·cos + m·sin + 1
  - sectors 9–10: sqrt(3)·m·cos − m·sin − 1
- R8: Every reference saturates to the range -16384 to +16384, including when the modulation index exceeds 1.0.
- R9: Phase A uses the accumulator angle. Phase B uses the angle minus 0x55555555, and phase C uses the angle plus 0x55555555, both modulo 2^32.
- R10: mod_idx is unsigned, and code 16384 means 1.0. The value applied to a sample is the one present at the strobe edge, even if mod_idx changes on the next cycle.
- R11: Between results, all three references hold their last delivered value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sample_stb | input | 1 | Take one sample and advance the phase |
| phase_inc | input | 32 | Phase step per strobe; 2^32 is one full cycle |
| mod_idx | input | 16 | Modulation index, unsigned; 16384 is 1.0 |
| ref_a | output | 16 | Phase A reference, signed; 16384 is +1.0 |
| ref_b | output | 16 | Phase B reference, lagging A by 120 degrees |
| ref_c | output | 16 | Phase C reference, leading A by 120 degrees |
| ref_valid | output | 1 | The references carry a new sample this cycle |

## Verification
A strobe accepted at one rising edge produces its three references and ref_valid three edges later. The angle register, the table read and the product stage each add one edge. The reference model in the bench is a four-deep queue of expected results that advances on every falling edge, so each comparison happens exactly in the cycle where the result is due. That queue also predicts ref_valid for every cycle, and a held copy of the last expected values checks the outputs between samples. Sector clamps are compared exactly. The evaluated segments are compared within a small tolerance that covers table and product rounding.

// File: rtl/dpwm_pkg.sv
package dpwm_pkg;

   localparam int NPH = 3;

   // pi/2 and sqrt(3) scaled by 2^30
   localparam longint PI_HALF_Q30 = 64'sd1686629713;
   localparam longint SQRT3_Q30   = 64'sd1859775393;

   typedef struct packed {
      logic clamp;       // sector pinned to a rail
      logic clamp_neg;   // rail is -1 rather than +1
      logic sin_neg;     // subtract the sine term
      logic off_pos;     // constant offset is +1 rather than -1
   } seg_plan_t;

   function automatic seg_plan_t seg_plan(input logic [3:0] sec);
      seg_plan_t sp;
      sp = '0;
      case (sec)
         4'd0, 4'd11: sp.clamp = 1'b1;
         4'd5, 4'd6: begin
            sp.clamp     = 1'b1;
            sp.clamp_neg = 1'b1;
         end
         4'd1, 4'd2: begin
            sp.sin_neg = 1'b0;
            sp.off_pos = 1'b0;
         end
         4'd3, 4'd4: begin
            sp.sin_neg = 1'b1;
            sp.off_pos = 1'b1;
         end
         4'd7, 4'd8: begin
            sp.sin_neg = 1'b0;
            sp.off_pos = 1'b1;
         end
         4'd9, 4'd10: begin
            sp.sin_neg = 1'b1;
            sp.off_pos = 1'b0;
         end
         default: sp.clamp = 1'b1;
      endcase
      return sp;
   endfunction

   // sin(idx/npts * pi/2) in Q30, by odd power series
   function automatic longint sin_q30(input int idx, input int npts);
      longint x, x2, term, sum;
      x    = (PI_HALF_Q30 * longint'(idx)) / longint'(npts);
      x2   = (x * x) >>> 30;
      term = x;
      sum  = x;
      for (int k = 1; k <= 8; k++) begin
         term = -((term * x2) >>> 30) / longint'((2 * k) * (2 * k + 1));
         sum  = sum + term;
      end
      return sum;
   endfunction

   // round a Q30 value to frac fractional bits
   function automatic longint q30_round(input longint v, input int frac);
      return (v + (longint'(1) << (29 - frac))) >>> (30 - frac);
   endfunction

endpackage

// File: rtl/dpwm_phase_acc.sv
module dpwm_phase_acc #(
   parameter int ACC_W = 32,
   parameter int MA_W  = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             stb,
   input  logic [ACC_W-1:0] inc,
   input  logic [MA_W-1:0]  ma,
   output logic [ACC_W-1:0] cap_ang,
   output logic [MA_W-1:0]  cap_ma,
   output logic             cap_vld
);

   logic [ACC_W-1:0] acc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q   <= '0;
         cap_ang <= '0;
         cap_ma  <= '0;
         cap_vld <= 1'b0;
      end else begin
         cap_vld <= stb;
         if (stb) begin
            cap_ang <= acc_q;
            cap_ma  <= ma;
            acc_q   <= acc_q + inc;
         end
      end
   end

endmodule

// File: rtl/dpwm_sin_lut.sv
module dpwm_sin_lut
   import dpwm_pkg::*;
#(
   parameter int ANG_W = 10,
   parameter int OUT_W = 16
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [ANG_W-1:0]        angle,
   output logic signed [OUT_W-1:0] sin_o,
   output logic signed [OUT_W-1:0] cos_o,
   output logic [3:0]              sector_o
);

   localparam int TBL_AW = ANG_W - 2;
   localparam int NLUT   = 1 << TBL_AW;
   localparam int FRAC   = OUT_W - 2;
   localparam logic [TBL_AW:0] NLUT_V = (TBL_AW + 1)'(NLUT);

   logic signed [OUT_W-1:0] tbl [0:NLUT];

   for (genvar i = 0; i <= NLUT; i++) begin : g_tbl
      localparam logic signed [OUT_W-1:0] ENTRY = OUT_W'(q30_round(sin_q30(i, NLUT), FRAC));
      assign tbl[i] = ENTRY;
   end

   logic [1:0]              quad_s, quad_c;
   logic [TBL_AW:0]         fwd, rev;
   logic signed [OUT_W-1:0] sin_c, cos_c;
   logic [ANG_W+3:0]        sec_prod_unused;
   logic [3:0]              sec_c;

   always_comb begin
      quad_s = angle[ANG_W-1 -: 2];
      quad_c = quad_s + 2'd1;
      fwd    = {1'b0, angle[TBL_AW-1:0]};
      rev    = NLUT_V - fwd;
      case (quad_s)
         2'd0:    sin_c = tbl[fwd];
         2'd1:    sin_c = tbl[rev];
         2'd2:    sin_c = -tbl[fwd];
         default: sin_c = -tbl[rev];
      endcase
      case (quad_c)
         2'd0:    cos_c = tbl[fwd];
         2'd1:    cos_c = tbl[rev];
         2'd2:    cos_c = -tbl[fwd];
         default: cos_c = -tbl[rev];
      endcase
      sec_prod_unused = {4'b0, angle} * (ANG_W + 4)'(12);
      sec_c           = sec_prod_unused[ANG_W+3:ANG_W];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sin_o    <= '0;
         cos_o    <= '0;
         sector_o <= '0;
      end else begin
         sin_o    <= sin_c;
         cos_o    <= cos_c;
         sector_o <= sec_c;
      end
   end

endmodule

// File: rtl/dpwm_seg_eval.sv
module dpwm_seg_eval
   import dpwm_pkg::*;
#(
   parameter int OUT_W   = 16,
   parameter int MA_W    = 16,
   parameter int MA_FRAC = 14
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    load,
   input  logic signed [OUT_W-1:0] sin_i,
   input  logic signed [OUT_W-1:0] cos_i,
   input  logic [3:0]              sector_i,
   input  logic [MA_W-1:0]         ma_i,
   output logic signed [OUT_W-1:0] ref_o
);

   localparam int FRAC = OUT_W - 2;
   localparam int P_W  = MA_W + OUT_W + 1;
   localparam int W_W  = P_W + OUT_W + 2;
   localparam longint ONE_L = longint'(1) << FRAC;
   localparam logic signed [W_W-1:0] ONE_W = W_W'(ONE_L);
   localparam logic signed [W_W-1:0] SQ3_W = W_W'(q30_round(SQRT3_Q30, FRAC));

   if (W_W > 63) begin : g_bad_w
      $error("dpwm_seg_eval: MA_W + 2*OUT_W too wide");
   end

   // stage 2: scale sine and cosine by the index
   logic signed [P_W-1:0] ma_x, sin_x, cos_x, prod_s, prod_c;
   logic signed [P_W-1:0] ms_q, mc_q;
   seg_plan_t             plan_q;

   always_comb begin
      ma_x   = {{(P_W - MA_W){1'b0}}, ma_i};
      sin_x  = {{(P_W - OUT_W){sin_i[OUT_W-1]}}, sin_i};
      cos_x  = {{(P_W - OUT_W){cos_i[OUT_W-1]}}, cos_i};
      prod_s = (ma_x * sin_x) >>> MA_FRAC;
      prod_c = (ma_x * cos_x) >>> MA_FRAC;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ms_q   <= '0;
         mc_q   <= '0;
         plan_q <= '0;
      end else begin
         ms_q   <= prod_s;
         mc_q   <= prod_c;
         plan_q <= seg_plan(sector_i);
      end
   end

   // stage 3: combine, clamp, saturate
   logic signed [W_W-1:0] mc_w, ms_w, kk, sum;
   logic signed [W_W-1:0] res;

   always_comb begin
      mc_w = {{(W_W - P_W){mc_q[P_W-1]}}, mc_q};
      ms_w = {{(W_W - P_W){ms_q[P_W-1]}}, ms_q};
      kk   = (mc_w * SQ3_W) >>> FRAC;
      sum  = kk + (plan_q.sin_neg ? -ms_w : ms_w) + (plan_q.off_pos ? ONE_W : -ONE_W);
      if (plan_q.clamp)
         res = plan_q.clamp_neg ? -ONE_W : ONE_W;
      else if (sum > ONE_W)
         res = ONE_W;
      else if (sum < -ONE_W)
         res = -ONE_W;
      else
         res = sum;
   end

   logic [W_W-OUT_W-1:0] res_hi_unused;
   assign res_hi_unused = res[W_W-1:OUT_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ref_o <= '0;
      else if (load)
         ref_o <= res[OUT_W-1:0];
   end

endmodule

// File: rtl/dpwm_ref_gen.sv
module dpwm_ref_gen
   import dpwm_pkg::*;
#(
   parameter int ACC_W   = 32,
   parameter int ANG_W   = 10,
   parameter int OUT_W   = 16,
   parameter int MA_W    = 16,
   parameter int MA_FRAC = 14
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    sample_stb,
   input  logic [ACC_W-1:0]        phase_inc,
   input  logic [MA_W-1:0]         mod_idx,
   output logic signed [OUT_W-1:0] ref_a,
   output logic signed [OUT_W-1:0] ref_b,
   output logic signed [OUT_W-1:0] ref_c,
   output logic                    ref_valid
);

   if (ANG_W < 6 || ANG_W > 12) begin : g_bad_ang
      $error("dpwm_ref_gen: ANG_W must lie in 6..12");
   end
   if (ACC_W <= ANG_W || ACC_W > 62) begin : g_bad_acc
      $error("dpwm_ref_gen: ACC_W must exceed ANG_W and stay below 63");
   end
   if (OUT_W < 8 || OUT_W > 24) begin : g_bad_out
      $error("dpwm_ref_gen: OUT_W must lie in 8..24");
   end
   if (MA_FRAC >= MA_W) begin : g_bad_ma
      $error("dpwm_ref_gen: MA_FRAC must be below MA_W");
   end

   localparam logic [ACC_W-1:0] THIRD = ACC_W'((longint'(1) << ACC_W) / 3);

   logic [ACC_W-1:0] cap_ang;
   logic [MA_W-1:0]  cap_ma, ma_q1;
   logic             v0, v1, v2;

   dpwm_phase_acc #(.ACC_W(ACC_W), .MA_W(MA_W)) u_acc (
      .clk     (clk),
      .rst_n   (rst_n),
      .stb     (sample_stb),
      .inc     (phase_inc),
      .ma      (mod_idx),
      .cap_ang (cap_ang),
      .cap_ma  (cap_ma),
      .cap_vld (v0)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ma_q1     <= '0;
         v1        <= 1'b0;
         v2        <= 1'b0;
         ref_valid <= 1'b0;
      end else begin
         ma_q1     <= cap_ma;
         v1        <= v0;
         v2        <= v1;
         ref_valid <= v2;
      end
   end

   logic signed [OUT_W-1:0] lane_ref [NPH];

   for (genvar l = 0; l < NPH; l++) begin : g_lane
      logic [ACC_W-1:0]        ang_unused;
      logic signed [OUT_W-1:0] s_l, c_l;
      logic [3:0]              sec_l;

      if (l == 0) begin : g_ref
         assign ang_unused = cap_ang;
      end else if (l == 1) begin : g_lag
         assign ang_unused = cap_ang - THIRD;
      end else begin : g_lead
         assign ang_unused = cap_ang + THIRD;
      end

      dpwm_sin_lut #(.ANG_W(ANG_W), .OUT_W(OUT_W)) u_lut (
         .clk      (clk),
         .rst_n    (rst_n),
         .angle    (ang_unused[ACC_W-1 -: ANG_W]),
         .sin_o    (s_l),
         .cos_o    (c_l),
         .sector_o (sec_l)
      );

      dpwm_seg_eval #(.OUT_W(OUT_W), .MA_W(MA_W), .MA_FRAC(MA_FRAC)) u_eval (
         .clk      (clk),
         .rst_n    (rst_n),
         .load     (v2),
         .sin_i    (s_l),
         .cos_i    (c_l),
         .sector_i (sec_l),
         .ma_i     (ma_q1),
         .ref_o    (lane_ref[l])
      );
   end

   assign ref_a = lane_ref[0];
   assign ref_b = lane_ref[1];
   assign ref_c = lane_ref[2];

endmodule

// File: rtl/dpwm_ref_gen_chk.sv
module dpwm_ref_gen_chk #(
   parameter int OUT_W = 16
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    sample_stb,
   input logic                    ref_valid,
   input logic signed [OUT_W-1:0] ref_a,
   input logic signed [OUT_W-1:0] ref_b,
   input logic signed [OUT_W-1:0] ref_c
);

   localparam logic signed [OUT_W-1:0] ONE = OUT_W'(1 << (OUT_W - 2));

   logic [3:0] stb_hist;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         stb_hist <= '0;
      else
         stb_hist <= {stb_hist[2:0], sample_stb};
   end

   // R1
   reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> !ref_valid);

   // R3
   valid_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ref_valid == stb_hist[3]);

   // R8
   ref_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_a <= ONE) && (ref_a >= -ONE) && (ref_b <= ONE) && (ref_b >= -ONE)
      && (ref_c <= ONE) && (ref_c >= -ONE));

   // R11
   ref_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ref_valid |-> ($stable(ref_a) && $stable(ref_b) && $stable(ref_c)));

endmodule

bind dpwm_ref_gen dpwm_ref_gen_chk #(.OUT_W(OUT_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .sample_stb (sample_stb),
   .ref_valid  (ref_valid),
   .ref_a      (ref_a),
   .ref_b      (ref_b),
   .ref_c      (ref_c)
);

// File: tb/dpwm_ref_gen_test.sv
`timescale 1ns/1ps
module dpwm_ref_gen_test;

   localparam int  ONE = 16384;
   localparam int  TOL = 8;
   localparam real PI  = 3.14159265358979323846;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sample_stb = 1'b0;
   logic [31:0] phase_inc = '0;
   logic [15:0] mod_idx = '0;
   logic signed [15:0] ref_a, ref_b, ref_c;
   logic        ref_valid;

   dpwm_ref_gen uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .sample_stb (sample_stb),
      .phase_inc  (phase_inc),
      .mod_idx    (mod_idx),
      .ref_a      (ref_a),
      .ref_b      (ref_b),
      .ref_c      (ref_c),
      .ref_valid  (ref_valid)
   );

   always #2 clk = ~clk;

   int checks = 0;
   int errors = 0;

   typedef struct {
      bit v;
      int val [3];
      int sec [3];
   } exp_t;

   exp_t        pipe [4];
   exp_t        held;
   logic [31:0] acc_m;

   // R9: lane 1 lags and lane 2 leads by a third of a cycle
   function automatic logic [31:0] lane_angle(input int l, input logic [31:0] a);
      if (l == 1) return a - 32'h5555_5555;
      if (l == 2) return a + 32'h5555_5555;
      return a;
   endfunction

   // R4, R5, R6, R7, R8
   task automatic model(input logic [31:0] ang, input int ma, output int val, output int sec);
      int  p;
      real th, m, c, s, r;
      p   = int'(ang[31:22]);
      sec = (p * 12) / 1024;
      th  = 2.0 * PI * real'(p) / 1024.0;
      m   = real'(ma) / 16384.0;
      c   = $sqrt(3.0) * m * $cos(th);
      s   = m * $sin(th);
      case (sec)
         0, 11:   r = 1.0;
         5, 6:    r = -1.0;
         1, 2:    r = c + s - 1.0;
         3, 4:    r = c - s + 1.0;
         7, 8:    r = c + s + 1.0;
         default: r = c - s - 1.0;
      endcase
      if (r > 1.0) r = 1.0;
      if (r < -1.0) r = -1.0;
      val = $rtoi(r * ONE + ((r >= 0.0) ? 0.5 : -0.5));
   endtask

   function automatic string tag_for(input int sec, input int val);
      if (sec == 0 || sec == 11) return "R5";
      if (sec == 5 || sec == 6) return "R6";
      if (val == ONE || val == -ONE) return "R8";
      return "R7";
   endfunction

   function automatic int lane_out(input int l);
      if (l == 1) return int'(ref_b);
      if (l == 2) return int'(ref_c);
      return int'(ref_a);
   endfunction

   task automatic chk(input string tag, input int act, input int exp, input int tol);
      checks++;
      if (act - exp > tol || exp - act > tol) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic clear_model();
      acc_m = '0;
      held  = '{v: 1'b0, val: '{0, 0, 0}, sec: '{0, 0, 0}};
      for (int i = 0; i < 4; i++) pipe[i] = held;
   endtask

   task automatic cyc(input bit stb, input logic [31:0] inc, input logic [15:0] ma);
      exp_t nw;
      @(negedge clk);
      // R3: valid due three edges after the accepting edge
      chk("R3 valid", int'(ref_valid), int'(pipe[3].v), 0);
      if (pipe[3].v) held = pipe[3];
      for (int l = 0; l < 3; l++) begin
         if (pipe[3].v)
            chk($sformatf("%s lane%0d sector%0d", tag_for(held.sec[l], held.val[l]), l, held.sec[l]),
                lane_out(l), held.val[l], TOL);
         else
            chk($sformatf("R11 hold lane%0d", l), lane_out(l), held.val[l], TOL);
      end
      for (int i = 3; i > 0; i--) pipe[i] = pipe[i-1];
      nw = '{v: stb, val: '{0, 0, 0}, sec: '{0, 0, 0}};
      if (stb) begin
         // R2, R10: angle and index taken at the strobe
         for (int l = 0; l < 3; l++) model(lane_angle(l, acc_m), int'(ma), nw.val[l], nw.sec[l]);
         acc_m = acc_m + inc;
      end
      pipe[0]    = nw;
      sample_stb = stb;
      phase_inc  = inc;
      mod_idx    = ma;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n      = 1'b0;
      sample_stb = 1'b0;
      repeat (3) begin
         @(negedge clk);
         // R1
         chk("R1 valid", int'(ref_valid), 0, 0);
         chk("R1 ref_a", int'(ref_a), 0, 0);
         chk("R1 ref_b", int'(ref_b), 0, 0);
         chk("R1 ref_c", int'(ref_c), 0, 0);
      end
      clear_model();
      rst_n = 1'b1;
   endtask

   task automatic finish_run();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      #800000;
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      clear_model();
      do_reset();

      // R2: zero step keeps every sample at angle 0
      repeat (8) cyc(1'b1, 32'd0, 16'd15565);
      repeat (4) cyc(1'b0, 32'd0, 16'd15565);
      chk("R2 angle zero ref_a", int'(ref_a), ONE, 0);

      // nominal index, full sweep, strobe every cycle
      repeat (700) cyc(1'b1, 32'd7158279, 16'd15565);

      // unity index, faster phase, sparse strobes
      for (int i = 0; i < 300; i++) cyc(i % 3 == 0, 32'd21474836, 16'd16384);

      // zero index: every segment collapses to its offset
      repeat (120) cyc(1'b1, 32'd21474836, 16'd0);

      // R8: index 1.5 drives segments into saturation
      repeat (650) cyc(1'b1, 32'd7158279, 16'd24576);

      // R10: index alternates every strobe
      for (int i = 0; i < 200; i++) cyc(1'b1, 32'd13421773, (i % 2 == 1) ? 16'd16384 : 16'd0);

      // R1: reset in mid-run, then restart from angle 0
      do_reset();
      repeat (40) cyc(1'b1, 32'd42949673, 16'd15565);
      repeat (6) cyc(1'b0, 32'd0, 16'd0);

      finish_run();
   end

endmodule